// File: doc/BRIEF.md
# Threshold-Masked Boolean Logic Unit

This unit evaluates single-bit Boolean logic on secrets that are never present as plain values. Every secret bit travels as M = 2T+1 shares, and the true bit is the XOR of those shares. A caller presents two shared operands and selects either a shared inversion or a shared conjunction. One clock later the unit returns a shared result, still split across M shares. The conjunction forms each result share from partial products of the input shares. It adds pairwise random cross terms, so no T internal wires together carry information about the secrets.

The result register also holds the unit's shared state bit. On every cycle without a new operation, that state is re-randomised. Fresh random bits are XORed into share pairs, so the individual shares keep changing while their XOR stays the same. All random bits come from one on-chip 32-bit maximal-length linear feedback shift register, which is loaded from a seed port. Each cycle it advances far enough to supply M(M-1)/2 cross-term bits and M-1 refresh bits.

Top module: `masked_share_unit`

## Requirements
- R1: The share count M equals 2T+1, where T (the tolerated number of probed wires) is a parameter; all share vectors are M bits wide, and share 0 is bit 0.
- R2: With op_sel = 0 (NOT), the captured result has share 0 equal to the inverse of a_sh[0], and every other share equal to the matching a_sh share, so the result's XOR is the inverse of the XOR of a_sh.
- R3: With op_sel = 1 (AND), the XOR of the captured result shares equals the AND of the XOR of a_sh and the XOR of b_sh, for any split of the operands into shares.
- R4: out_valid is high in exactly the cycle after a cycle with in_valid high, and low otherwise; the result shares are registered.
- R5: In every cycle where in_valid is low, the held result shares are refreshed: a fresh random bit r_k is XORed into shares k and M-1 for k = 0 to M-2, leaving the XOR of all shares unchanged.
- R6: Refresh actually randomises: over a run of idle cycles, the held share vector changes.
- R7: With seed_load high, the generator state is set from seed, so the same seed followed by the same operation yields identical AND result shares, while different seeds yield different AND result shares for the same operands.
- R8: A seed of all zeros is replaced by a fixed non-zero constant, so the generator never holds the all-zero state and refresh keeps working.
- R9: While rst_n is low, out_valid is 0 and all result shares are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load the random generator from seed this cycle |
| seed | input | 32 | Generator seed value |
| in_valid | input | 1 | Operands and op_sel are valid; capture a new result |
| op_sel | input | 1 | 0 = shared NOT of a_sh, 1 = shared AND of a_sh and b_sh |
| a_sh | input | M | Shares of operand a |
| b_sh | input | M | Shares of operand b |
| out_valid | output | 1 | New result present on c_sh this cycle |
| c_sh | output | M | Shares of the result / held state bit |

## Verification
The bench aims at share splits where the plain operands agree but the shares differ, and at all-ones and all-zeros share patterns. A conjunction that mixed up a mirrored cross term or dropped one pair would then return a result whose XOR is wrong. It holds results through long idle runs, which exposes a refresh that touches only one share of a pair (the XOR flips) or one that never fires (the shares freeze). Reloading the same seed, trying several different seeds, and loading an all-zero seed catch a generator that ignores the seed or that locks up at zero.

// File: rtl/msk_pkg.sv
package msk_pkg;
  localparam int LFSR_W = 32;
  localparam logic [LFSR_W-1:0] SEED_FALLBACK = 32'h1D87_2B41;

  // Fibonacci step for x^32 + x^22 + x^2 + x + 1 (maximal length)
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // Flat position of the pair (i, j), i < j, among m shares
  function automatic int pair_index(input int i, input int j, input int m);
    int p;
    p = 0;
    for (int k = 0; k < i; k++) p += m - 1 - k;
    return p + (j - i - 1);
  endfunction

  // Mirrored cross term; the inner XOR is evaluated first
  function automatic logic mirror_term(input logic z_fwd, input logic ai, input logic bj,
                                       input logic aj, input logic bi);
    logic inner;
    inner = z_fwd ^ (ai & bj);
    return inner ^ (aj & bi);
  endfunction
endpackage

// File: rtl/msk_prng.sv
module msk_prng
  import msk_pkg::*;
#(
  parameter int NBITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed,
  output logic [NBITS-1:0]  rnd
);
  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] state_adv;
  logic [LFSR_W-1:0] seed_fixed;
  logic              seed_is_zero;

  always_comb begin
    state_adv = state_q;
    rnd       = '0;
    for (int k = 0; k < NBITS; k++) begin
      state_adv = lfsr_next(state_adv);
      rnd[k]    = state_adv[0];
    end
  end

  assign seed_is_zero = (seed == '0);
  assign seed_fixed   = seed_is_zero ? SEED_FALLBACK : seed;

  always_ff @(posedge clk) begin
    if (!rst_n)         state_q <= SEED_FALLBACK;
    else if (seed_load) state_q <= seed_fixed;
    else                state_q <= state_adv;
  end

  p_prng_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  p_seed_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load && !seed_is_zero |=> state_q == $past(seed));
endmodule

// File: rtl/msk_and_core.sv
module msk_and_core
  import msk_pkg::*;
#(
  parameter int M = 3
) (
  input  logic [M-1:0]         a_sh,
  input  logic [M-1:0]         b_sh,
  input  logic [M*(M-1)/2-1:0] z_rand,
  output logic [M-1:0]         c_sh
);
  localparam int NP = M * (M - 1) / 2;

  logic [NP-1:0] z_fwd;
  logic [NP-1:0] z_rev;

  for (genvar gi = 0; gi < M; gi++) begin : g_row
    for (genvar gj = gi + 1; gj < M; gj++) begin : g_col
      localparam int P = pair_index(gi, gj, M);
      assign z_fwd[P] = z_rand[P];
      assign z_rev[P] = mirror_term(z_rand[P], a_sh[gi], b_sh[gj], a_sh[gj], b_sh[gi]);
    end
  end

  always_comb begin
    for (int i = 0; i < M; i++) begin
      c_sh[i] = a_sh[i] & b_sh[i];
      for (int j = 0; j < M; j++) begin
        if (j > i)      c_sh[i] = c_sh[i] ^ z_fwd[pair_index(i, j, M)];
        else if (j < i) c_sh[i] = c_sh[i] ^ z_rev[pair_index(j, i, M)];
      end
    end
  end
endmodule

// File: rtl/msk_refresh.sv
module msk_refresh #(
  parameter int M = 3
) (
  input  logic [M-1:0] sh_in,
  input  logic [M-2:0] r_bits,
  output logic [M-1:0] sh_out
);
  logic last_mix;

  for (genvar gk = 0; gk < M - 1; gk++) begin : g_low
    assign sh_out[gk] = sh_in[gk] ^ r_bits[gk];
  end

  assign last_mix   = ^r_bits;
  assign sh_out[M-1] = sh_in[M-1] ^ last_mix;

  always_comb begin
    if (^sh_in !== 1'bx)
      a_refresh_parity_r5: assert (^sh_out == ^sh_in);
  end
endmodule

// File: rtl/masked_share_unit.sv
module masked_share_unit
  import msk_pkg::*;
#(
  parameter int T = 1,
  localparam int M = 2 * T + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed,
  input  logic              in_valid,
  input  logic              op_sel,
  input  logic [M-1:0]      a_sh,
  input  logic [M-1:0]      b_sh,
  output logic              out_valid,
  output logic [M-1:0]      c_sh
);
  localparam int NP = M * (M - 1) / 2;
  localparam int NR = M - 1;
  localparam int NB = NP + NR;

  logic [NB-1:0] rnd;
  logic [NP-1:0] z_bits;
  logic [NR-1:0] r_bits;
  logic [M-1:0]  not_res;
  logic [M-1:0]  and_res;
  logic [M-1:0]  op_res;
  logic [M-1:0]  refreshed;
  logic [M-1:0]  c_q;
  logic          v_q;
  logic          capture;
  logic          refresh_evt;

  msk_prng #(.NBITS(NB)) u_prng (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed_load(seed_load),
    .seed     (seed),
    .rnd      (rnd)
  );

  assign z_bits = rnd[NP-1:0];
  assign r_bits = rnd[NB-1:NP];

  msk_and_core #(.M(M)) u_and (
    .a_sh  (a_sh),
    .b_sh  (b_sh),
    .z_rand(z_bits),
    .c_sh  (and_res)
  );

  msk_refresh #(.M(M)) u_refresh (
    .sh_in (c_q),
    .r_bits(r_bits),
    .sh_out(refreshed)
  );

  assign not_res     = {a_sh[M-1:1], ~a_sh[0]};
  assign op_res      = op_sel ? and_res : not_res;
  assign capture     = in_valid;
  assign refresh_evt = !in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_q <= '0;
      v_q <= 1'b0;
    end else begin
      v_q <= capture;
      if (capture)          c_q <= op_res;
      else if (refresh_evt) c_q <= refreshed;
    end
  end

  assign out_valid = v_q;
  assign c_sh      = c_q;

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_not_shares_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !op_sel |=> c_sh == ($past(a_sh) ^ M'(1)));
  p_and_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_sel |=> (^c_sh) == ((^$past(a_sh)) & (^$past(b_sh))));
  p_hold_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (^c_sh) == $past(^c_sh));
endmodule

// File: tb/masked_share_unit_test.sv
`timescale 1ns/1ps
module masked_share_unit_test;
  localparam int T = 1;
  localparam int M = 2 * T + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          seed_load = 1'b0;
  logic [31:0]   seed = '0;
  logic          in_valid = 1'b0;
  logic          op_sel = 1'b0;
  logic [M-1:0]  a_sh = '0;
  logic [M-1:0]  b_sh = '0;
  logic          out_valid;
  logic [M-1:0]  c_sh;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  masked_share_unit #(.T(T)) uut (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed(seed),
    .in_valid(in_valid), .op_sel(op_sel), .a_sh(a_sh), .b_sh(b_sh),
    .out_valid(out_valid), .c_sh(c_sh)
  );

  function automatic logic plain(input logic [M-1:0] v);
    logic r;
    r = 1'b0;
    for (int i = 0; i < M; i++) r = r ^ v[i];
    return r;
  endfunction

  function automatic logic [M-1:0] want_not(input logic [M-1:0] a);
    logic [M-1:0] r;
    r = a;
    r[0] = !a[0];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic op, input logic [M-1:0] a, input logic [M-1:0] b);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; a_sh = a; b_sh = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic load_seed(input logic [31:0] s);
    @(negedge clk);
    seed_load = 1'b1; seed = s;
    @(negedge clk);
    seed_load = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [M-1:0] a, b, first, prev, s0v;
    bit changed, differ;
    process::self().srandom(32'h5EED_0042);

    repeat (3) @(negedge clk);
    // R9 reset state
    check(out_valid == 1'b0 && c_sh == '0, "R9", {out_valid, c_sh}, 0);
    // R1 share width
    check($bits(c_sh) == 2 * T + 1, "R1", $bits(c_sh), 2 * T + 1);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R4 idle", out_valid, 0);

    // directed corners
    run_op(1'b1, '1, '1);
    check(out_valid, "R4", out_valid, 1);
    check(plain(c_sh) == 1'b1, "R3 all-ones", plain(c_sh), 1);
    run_op(1'b1, '0, '1);
    check(plain(c_sh) == 1'b0, "R3 zero a", plain(c_sh), 0);
    run_op(1'b0, '0, '0);
    check(c_sh == want_not('0), "R2 zeros", c_sh, want_not('0));
    @(negedge clk);
    check(out_valid == 1'b0, "R4 single pulse", out_valid, 0);

    // constrained random, each result held through idle refresh cycles
    for (int n = 0; n < 60; n++) begin
      logic op;
      int idle;
      a = M'($urandom); b = M'($urandom); op = 1'($urandom);
      run_op(op, a, b);
      check(out_valid, "R4 random", out_valid, 1);
      if (op) check(plain(c_sh) == (plain(a) & plain(b)), "R3", plain(c_sh), plain(a) & plain(b));
      else    check(c_sh == want_not(a), "R2", c_sh, want_not(a));
      first = c_sh;
      changed = 0;
      idle = 8 + int'($urandom % 4);
      for (int k = 0; k < idle; k++) begin
        prev = c_sh;
        @(negedge clk);
        if (c_sh != prev) changed = 1;
        check(plain(c_sh) == plain(first), "R5", plain(c_sh), plain(first));
      end
      check(changed, "R6", c_sh, first);
    end

    // back-to-back operations
    run_op(1'b1, 3'b101, 3'b011);
    check(plain(c_sh) == 1'b0, "R3 b2b", plain(c_sh), 0);

    // R7 seed reproducibility and dependence
    load_seed(32'hCAFE_1234);
    run_op(1'b1, 3'b110, 3'b011);
    s0v = c_sh;
    load_seed(32'hCAFE_1234);
    run_op(1'b1, 3'b110, 3'b011);
    check(c_sh == s0v, "R7 same seed", c_sh, s0v);
    differ = 0;
    for (int s = 1; s <= 8; s++) begin
      load_seed(32'h0101_0101 * s + 32'h77);
      run_op(1'b1, 3'b110, 3'b011);
      check(plain(c_sh) == 1'b0, "R3 seeded", plain(c_sh), 0);
      if (c_sh != s0v) differ = 1;
    end
    check(differ, "R7 seeds differ", differ, 1);

    // R8 zero seed still gives a running generator
    load_seed(32'h0);
    run_op(1'b0, 3'b001, 3'b000);
    first = c_sh;
    changed = 0;
    for (int k = 0; k < 10; k++) begin
      prev = c_sh;
      @(negedge clk);
      if (c_sh != prev) changed = 1;
    end
    check(changed, "R8", c_sh, first);
    check(plain(c_sh) == plain(first), "R5 after zero seed", plain(c_sh), plain(first));

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule